// File: doc/BRIEF.md
# Four-Stack Execution Core

This block is a small processor core with no general registers. All of its architectural state lives in four last-in-first-out stacks: a display stack, an address stack whose top entry is the instruction pointer, and two working stacks. Each instruction names one stack as its destination and first operand. The second operand is either the top of another stack, the entry just below the top of the same stack, or an 18-bit immediate. The core reads its program one byte at a time through a fetch port with asynchronous read. A jump is a push onto the address stack, and a return is a pop from it.

Execution is started by either of two inputs. Each change of level on the step input runs exactly one instruction. The run input keeps instructions going for as long as it is held high. A read port lets a display, or any other reader, view any entry of any stack.

Top module: `fsc_core`

## Requirements
- R1: The first byte holds the opcode in bits [2:0], the immediate flag in bit 3, the destination stack in bits [5:4] (00 display, 01 address, 10 work A, 11 work B) and, when the flag is 0, the source stack in bits [7:6]. When the flag is 1, the instruction is 3 bytes read little-endian from IP, IP+1 and IP+2, and bits [23:6] are a zero-extended immediate.
- R2: When the source stack equals the destination stack, the second operand is the entry just below that stack's top.
- R3: Opcode 0 pushes the second operand. Opcodes 1, 2 and 3 push first+second, first−second and first×second, each modulo 2^24, without popping the first operand.
- R4: Opcode 4 pushes first/second (integer quotient), and pushes 0 when the divisor is 0.
- R5: Opcode 5 adds one extra byte to the advancing IP when the operands differ. Opcode 6 does the same when first ≤ second.
- R6: Opcode 7 pops the destination stack. Entries vacated at the bottom read as 0, and popping an empty stack leaves it reading 0.
- R7: After an instruction, the top of the address stack advances by the instruction length (1 or 3 bytes). An instruction that pushes or pops the address stack does not advance it, so a push acts as a jump and a pop as a return.
- R8: Each stack holds 16 entries. A push onto a full stack discards the oldest entry.
- R9: Each level change of step_i runs exactly one instruction. With step_i steady and run_i low, nothing runs.
- R10: While run_i is high, instructions run back to back. After run_i falls, no further instruction starts.
- R11: disp_data_o shows entry disp_idx_i (0 = top) of the stack chosen by disp_stk_i, using the same selector code as R1.
- R12: After reset, every stack reads 0, so execution starts at address 0.
- R13: retire_o is a one-cycle pulse for each instruction. The updated stacks are visible from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Single-step switch; each level change runs one instruction |
| run_i | input | 1 | Free-run enable |
| fetch_addr_o | output | ADDR_W | Byte address of the program fetch |
| fetch_data_i | input | 8 | Program byte at fetch_addr_o, same cycle |
| disp_stk_i | input | 2 | Stack chosen for the read port |
| disp_idx_i | input | IDX_W | Entry depth for the read port (0 = top) |
| disp_data_o | output | W | Value of the chosen entry |
| ip_o | output | W | Top of the address stack |
| retire_o | output | 1 | Pulses in the cycle an instruction executes |

## Verification
A stepped program exercises every opcode with both short forms (distinct-stack and same-stack source) and long immediate forms. It covers a wrapping subtraction, a zero divisor, both skip conditions taken and not taken, an IP-relative push used as a jump, and a pop used as a return; the expected IP after each step separates length, skip and jump errors. A free-run program pushes seventeen values and then pops seventeen, which shows the oldest entry being discarded, zero fill from below and the empty-stack pop. The read port checks depth and stack selection. Stretches with step_i steady, and after run_i falls, show that no instruction runs uncommanded.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  localparam int NSTK    = 4;
  localparam int IMM_W   = 18;
  localparam int IMM_BIT = 3;

  typedef enum logic [1:0] {
    SEL_DSP = 2'd0,
    SEL_ADR = 2'd1,
    SEL_WKA = 2'd2,
    SEL_WKB = 2'd3
  } sel_e;

  typedef enum logic [2:0] {
    OP_PUSH = 3'd0,
    OP_ADD  = 3'd1,
    OP_SUB  = 3'd2,
    OP_MUL  = 3'd3,
    OP_DIV  = 3'd4,
    OP_SKNE = 3'd5,
    OP_SKLE = 3'd6,
    OP_POP  = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_F0   = 3'd1,
    ST_F1   = 3'd2,
    ST_F2   = 3'd3,
    ST_EXEC = 3'd4
  } st_e;

  typedef struct packed {
    op_e              op;
    logic             imm_f;
    sel_e             s1;
    sel_e             s2;
    logic [IMM_W-1:0] imm;
  } dec_t;
endpackage

// File: rtl/fsc_stack.sv
module fsc_stack #(
  parameter int W     = 24,
  parameter int DEPTH = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      push_i,
  input  logic                      pop_i,
  input  logic                      set_i,
  input  logic [W-1:0]              din_i,
  output logic [DEPTH-1:0][W-1:0]   ent_o
);
  logic [DEPTH-1:0][W-1:0] ent_q;

  // slot 0 is the top; zeros shift in from below on pop
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_q <= '0;
    end else if (push_i) begin
      ent_q[0] <= din_i;
      for (int i = 1; i < DEPTH; i++) ent_q[i] <= ent_q[i-1];
    end else if (pop_i) begin
      for (int i = 0; i < DEPTH-1; i++) ent_q[i] <= ent_q[i+1];
      ent_q[DEPTH-1] <= '0;
    end else if (set_i) begin
      ent_q[0] <= din_i;
    end
  end

  assign ent_o = ent_q;
endmodule

// File: rtl/fsc_decode.sv
module fsc_decode
  import fsc_pkg::*;
(
  input  logic [23:0] word_i,
  output dec_t        dec_o,
  output logic [1:0]  len_o
);
  always_comb begin
    dec_o.op    = op_e'(word_i[2:0]);
    dec_o.imm_f = word_i[IMM_BIT];
    dec_o.s1    = sel_e'(word_i[5:4]);
    dec_o.s2    = sel_e'(word_i[7:6]);
    dec_o.imm   = word_i[23:6];
    len_o       = word_i[IMM_BIT] ? 2'd3 : 2'd1;
  end
endmodule

// File: rtl/fsc_alu.sv
module fsc_alu
  import fsc_pkg::*;
#(
  parameter int W = 24
) (
  input  op_e          op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o,
  output logic         cond_o
);
  always_comb begin
    res_o  = '0;
    cond_o = 1'b0;
    unique case (op_i)
      OP_PUSH: res_o = b_i;
      OP_ADD:  res_o = a_i + b_i;
      OP_SUB:  res_o = a_i - b_i;
      OP_MUL:  res_o = a_i * b_i;
      OP_DIV:  res_o = (b_i == '0) ? '0 : a_i / b_i;
      OP_SKNE: cond_o = (a_i != b_i);
      OP_SKLE: cond_o = (a_i <= b_i);
      OP_POP:  res_o = '0;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/fsc_core.sv
module fsc_core
  import fsc_pkg::*;
#(
  parameter int W      = 24,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 9,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              run_i,
  output logic [ADDR_W-1:0] fetch_addr_o,
  input  logic [7:0]        fetch_data_i,
  input  logic [1:0]        disp_stk_i,
  input  logic [IDX_W-1:0]  disp_idx_i,
  output logic [W-1:0]      disp_data_o,
  output logic [W-1:0]      ip_o,
  output logic              retire_o
);
  st_e         st_q;
  logic [23:0] ir_q;
  logic        step_q, pend_q, pend_d, start, exec;
  logic [1:0]  off;

  dec_t        dec;
  logic [1:0]  len;
  op_e         op;
  sel_e        s1;
  logic        imm_f;

  logic [NSTK-1:0][DEPTH-1:0][W-1:0] ent_all;
  logic [NSTK-1:0][W-1:0]            tops, secs;
  logic [NSTK-1:0]                   push_v, pop_v, set_v;
  logic [NSTK-1:0][W-1:0]            din_v;

  logic [W-1:0] a_val, b_val, res, ip_top, ip_next;
  logic         cond, ip_wr;

  // run control
  assign start  = (st_q == ST_IDLE) && (run_i || pend_q);
  assign pend_d = (start ? 1'b0 : pend_q) | (step_i ^ step_q);
  assign exec   = (st_q == ST_EXEC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ir_q   <= '0;
      step_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      step_q <= step_i;
      pend_q <= pend_d;
      unique case (st_q)
        ST_IDLE: if (start) st_q <= ST_F0;
        ST_F0: begin
          ir_q <= {16'h0, fetch_data_i};
          st_q <= fetch_data_i[IMM_BIT] ? ST_F1 : ST_EXEC;
        end
        ST_F1: begin
          ir_q[15:8] <= fetch_data_i;
          st_q       <= ST_F2;
        end
        ST_F2: begin
          ir_q[23:16] <= fetch_data_i;
          st_q        <= ST_EXEC;
        end
        ST_EXEC: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (st_q)
      ST_F1:   off = 2'd1;
      ST_F2:   off = 2'd2;
      default: off = 2'd0;
    endcase
  end

  assign fetch_addr_o = ip_top[ADDR_W-1:0] + ADDR_W'(off);

  // decode and operand select
  fsc_decode u_dec (
    .word_i (ir_q),
    .dec_o  (dec),
    .len_o  (len)
  );

  assign op    = dec.op;
  assign s1    = dec.s1;
  assign imm_f = dec.imm_f;

  assign ip_top = tops[SEL_ADR];
  assign a_val  = tops[s1];
  assign b_val  = imm_f ? {{(W-IMM_W){1'b0}}, dec.imm}
                        : ((dec.s2 == s1) ? secs[s1] : tops[dec.s2]);

  fsc_alu #(.W(W)) u_alu (
    .op_i   (op),
    .a_i    (a_val),
    .b_i    (b_val),
    .res_o  (res),
    .cond_o (cond)
  );

  assign ip_wr   = (s1 == SEL_ADR) && ((op <= OP_DIV) || (op == OP_POP));
  assign ip_next = ip_top + {{(W-2){1'b0}}, len} + {{(W-1){1'b0}}, cond};

  always_comb begin
    for (int k = 0; k < NSTK; k++) begin
      push_v[k] = exec && (int'(s1) == k) && (op <= OP_DIV);
      pop_v[k]  = exec && (int'(s1) == k) && (op == OP_POP);
      set_v[k]  = exec && (k == int'(SEL_ADR)) && !ip_wr;
      din_v[k]  = set_v[k] ? ip_next : res;
    end
  end

  // stacks
  for (genvar k = 0; k < NSTK; k++) begin : g_stk
    fsc_stack #(.W(W), .DEPTH(DEPTH)) u_stk (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .push_i (push_v[k]),
      .pop_i  (pop_v[k]),
      .set_i  (set_v[k]),
      .din_i  (din_v[k]),
      .ent_o  (ent_all[k])
    );
    assign tops[k] = ent_all[k][0];
    assign secs[k] = ent_all[k][1];
  end

  assign disp_data_o = ent_all[disp_stk_i][disp_idx_i];
  assign ip_o        = ip_top;
  assign retire_o    = exec;
endmodule

// File: rtl/fsc_core_chk.sv
module fsc_core_chk
  import fsc_pkg::*;
#(
  parameter int W = 24
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   run_i,
  input logic [2:0]             st_i,
  input logic                   pend_i,
  input logic                   retire_i,
  input logic [W-1:0]           ip_i,
  input logic [2:0]             op_i,
  input logic [1:0]             s1_i,
  input logic                   imm_f_i,
  input logic [W-1:0]           a_i,
  input logic [W-1:0]           b_i,
  input logic [NSTK-1:0][W-1:0] tops_i,
  input logic [NSTK-1:0][W-1:0] secs_i
);
  a_r13_retire_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_i |=> !retire_i);

  a_r7_adv_short: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_i && !imm_f_i && s1_i != 2'd1 && op_i <= 3'd4)
    |=> ip_i == W'($past(ip_i) + W'(1)));

  a_r7_adv_long: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_i && imm_f_i && s1_i != 2'd1 && op_i <= 3'd4)
    |=> ip_i == W'($past(ip_i) + W'(3)));

  a_r5_skip_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_i && imm_f_i && s1_i != 2'd1 && op_i == 3'd5 && a_i != b_i)
    |=> ip_i == W'($past(ip_i) + W'(4)));

  a_r4_div_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_i && op_i == 3'd4 && b_i == '0 && s1_i != 2'd1)
    |=> tops_i[$past(s1_i)] == '0);

  a_r6_pop_dsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_i && op_i == 3'd7 && s1_i == 2'd0)
    |=> tops_i[0] == $past(secs_i[0]));

  a_r9_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_IDLE && !run_i && !pend_i) |=> st_i == ST_IDLE);
endmodule

bind fsc_core fsc_core_chk #(.W(W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .run_i    (run_i),
  .st_i     (st_q),
  .pend_i   (pend_q),
  .retire_i (retire_o),
  .ip_i     (ip_o),
  .op_i     (op),
  .s1_i     (s1),
  .imm_f_i  (imm_f),
  .a_i      (a_val),
  .b_i      (b_val),
  .tops_i   (tops),
  .secs_i   (secs)
);

// File: tb/fsc_core_tb.sv
module fsc_core_tb_top;
  localparam int W = 24, DEPTH = 16, ADDR_W = 9, IDX_W = 4;

  logic clk = 0, rst_ni = 0, step_i = 0, run_i = 0;
  logic [ADDR_W-1:0] fetch_addr;
  logic [7:0]        fetch_data;
  logic [1:0]        disp_stk = 0;
  logic [IDX_W-1:0]  disp_idx = 0;
  logic [W-1:0]      disp_data, ip_o;
  logic              retire;

  logic [7:0] mem [512];
  assign fetch_data = mem[fetch_addr];

  always #10 clk = ~clk;

  fsc_core #(.W(W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .step_i(step_i), .run_i(run_i),
    .fetch_addr_o(fetch_addr), .fetch_data_i(fetch_data),
    .disp_stk_i(disp_stk), .disp_idx_i(disp_idx),
    .disp_data_o(disp_data), .ip_o(ip_o), .retire_o(retire)
  );

  int total = 0, bad = 0, retire_cnt = 0;

  typedef struct { int ip; int idx; int data; string tag; } item_t;
  item_t q [$];

  task automatic chk(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_item(int ip, int idx, int data, string tag);
    item_t it;
    it.ip = ip; it.idx = idx; it.data = data; it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: after each retire, compare IP and a display-stack entry
  initial begin
    forever begin
      @(negedge clk);
      if (retire) begin
        retire_cnt++;
        @(negedge clk);
        if (q.size() > 0) begin
          item_t it;
          it = q.pop_front();
          disp_stk = 2'd0;
          disp_idx = IDX_W'(it.idx);
          #1;
          chk({it.tag, " ip"}, ip_o, it.ip);
          chk({it.tag, " data"}, disp_data, it.data);
          disp_idx = '0;
        end
      end
    end
  end

  function automatic logic [7:0] e8(int op, int s1, int s2);
    return {s2[1:0], s1[1:0], 1'b0, op[2:0]};
  endfunction

  task automatic put24(int a, int op, int s1, int imm);
    logic [23:0] w;
    w = {imm[17:0], s1[1:0], 1'b1, op[2:0]};
    mem[a] = w[7:0]; mem[a+1] = w[15:8]; mem[a+2] = w[23:16];
  endtask

  task automatic do_reset();
    rst_ni = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic step_one(int ip, int idx, int data, string tag);
    expect_item(ip, idx, data, tag);
    step_i = ~step_i;
    drain();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int c0;
    // ---------------- program A (stepped) ----------------
    for (int i = 0; i < 512; i++) mem[i] = 8'h07;
    put24(0, 0, 0, 100);
    put24(3, 1, 0, 23);
    put24(6, 0, 2, 7);
    mem[9]  = e8(2, 0, 2);
    mem[10] = e8(3, 0, 0);
    put24(11, 4, 0, 100);
    mem[14] = e8(4, 0, 3);
    mem[15] = e8(7, 0, 0);
    put24(16, 2, 0, 200);
    mem[19] = e8(7, 0, 0);
    put24(20, 5, 0, 142);
    put24(23, 5, 0, 5);
    mem[26] = 8'hFF;
    put24(27, 6, 0, 142);
    mem[30] = 8'hFF;
    put24(31, 6, 0, 141);
    put24(34, 0, 1, 40);
    put24(40, 0, 3, 50);
    mem[43] = e8(0, 0, 3);
    put24(44, 1, 1, 6);
    mem[50] = e8(7, 0, 0);
    mem[51] = e8(7, 1, 0);

    do_reset();
    #1;
    chk("R12 reset ip", ip_o, 0);
    chk("R12 reset retire", retire, 0);
    disp_stk = 2'd2; disp_idx = 4'd5; #1;
    chk("R12 reset stack entry", disp_data, 0);
    disp_stk = 2'd0; disp_idx = 0;

    repeat (20) @(negedge clk);
    chk("R9 no toggle no exec", retire_cnt, 0);

    step_one(3,  0, 100,      "R1 R3 push imm");
    step_one(6,  1, 100,      "R3 add keeps operand");
    step_one(9,  0, 123,      "R1 push to work A");
    step_one(10, 0, 116,      "R3 sub stacks");
    step_one(11, 0, 14268,    "R2 mul same stack");
    step_one(14, 0, 142,      "R4 div imm");
    step_one(15, 0, 0,        "R4 div by zero");
    step_one(16, 0, 142,      "R6 pop");
    step_one(19, 0, 16777158, "R3 sub wrap");
    step_one(20, 0, 142,      "R6 pop again");
    step_one(23, 0, 142,      "R5 ne not taken");
    step_one(27, 0, 142,      "R5 ne taken");
    step_one(31, 0, 142,      "R5 le taken");
    step_one(34, 0, 142,      "R5 le not taken");
    step_one(40, 0, 142,      "R7 push ip jump");
    step_one(43, 0, 142,      "R7 push work B");
    step_one(44, 0, 50,       "R1 push from stack");
    step_one(50, 0, 50,       "R7 ip relative jump");
    step_one(51, 0, 142,      "R6 pop after jump");
    step_one(44, 0, 142,      "R7 pop ip return");

    c0 = retire_cnt;
    repeat (20) @(negedge clk);
    chk("R9 steady step no exec", retire_cnt, c0);

    disp_stk = 2'd2; disp_idx = 0; #1;
    chk("R11 read work A top", disp_data, 7);
    disp_stk = 2'd1; disp_idx = 4'd1; #1;
    chk("R11 read address stack depth1", disp_data, 34);
    disp_stk = 2'd0; disp_idx = 0;

    // ---------------- program B (free run) ----------------
    for (int i = 0; i < 512; i++) mem[i] = 8'h07;
    for (int k = 0; k < 17; k++) put24(3*k, 1, 0, 1);
    put24(68, 0, 1, 68);
    do_reset();
    for (int k = 0; k < 17; k++) begin
      if (k == 15)      expect_item(48, 15, 1, "R8 full stack");
      else if (k == 16) expect_item(51, 15, 2, "R8 oldest dropped");
      else              expect_item(3*(k+1), 0, k+1, "R10 run add");
    end
    for (int j = 1; j <= 17; j++) begin
      if (j == 1)       expect_item(52, 14, 2, "R6 zero fill below");
      else if (j == 17) expect_item(68, 0, 0, "R6 pop empty");
      else              expect_item(51+j, 0, (17-j >= 2) ? 17-j : 0, "R6 run pop");
    end
    expect_item(68, 0, 0, "R7 self jump");
    run_i = 1;
    drain();
    run_i = 0;
    repeat (10) @(negedge clk);
    c0 = retire_cnt;
    repeat (20) @(negedge clk);
    chk("R10 stop after run low", retire_cnt, c0);
    chk("R13 retire low when stopped", retire, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule